// File: doc/BRIEF.md
# Status Word Swap Sequencer

This block carries out the context swap that a processor core performs when it takes an interrupt of one class. The caller picks the class and presents the live status word: a 64-bit mask, a 64-bit address and the 2-bit condition code that is kept outside the mask. On a start pulse the sequencer builds the old status word, with the condition code merged into the mask. It stores that word, plus any parameters that belong to the class, in fixed slots of a low-memory save area. It then fetches the class's new mask and address from the same area and installs them as the current status word.

All traffic goes through one word-wide synchronous memory port. A read returns its data on the cycle after the request. Each class owns a slot of `SLOT_STRIDE` bytes that starts at `SAVE_BASE + class * SLOT_STRIDE`. Every field in the save area is held big-endian, while the port numbers its byte lanes little-endian. Loading a mask that has the wait bit set puts the core into the halted state.

Top module: `psw_swap_seq`

## Requirements
- R1: After reset, busy, done, mem_req, mem_we and halted are 0, and psw_mask, psw_addr and psw_cc are 0.
- R2: Classes are encoded restart=0, external=1, supervisor call=2, program=3. The slot base is SAVE_BASE + class*SLOT_STRIDE. Memory requests come in this fixed order: parameter write at base+32, old-mask write at base+0, old-address write at base+8, new-mask read at base+16, new-address read at base+24.
- R3: The saved old mask equals cur_mask with bits 45:44 replaced by cur_cc.
- R4: Every word is stored big-endian. The byte at save-area offset a+k lies on port lane k (bits 8k+7:8k), so a value's most significant byte sits on lane 0.
- R5: For a supervisor call, the saved address is cur_addr plus the instruction length. The parameter word holds the 16-bit length in bits 63:48, int_code in bits 47:32, and zero below.
- R6: ilen_sel values 2, 4 and 6 give the length directly. Value 1 takes the length from the opcode byte, and value 3 does the same and also adds the length to the saved address of a program exception. The opcode rule is top bits 00 gives 2, 01 or 10 gives 4, and 11 gives 6. A program exception saves cur_addr otherwise, and it stores the length and int_code in the parameter word laid out as in R5.
- R7: A restart performs no parameter write. An external interruption writes a parameter word with a length field of 0 and int_code in bits 47:32.
- R8: At the end of the sequence, psw_mask and psw_addr take the two words read from the slot, and psw_cc takes bits 45:44 of the new mask.
- R9: halted is set when the loaded mask has bit WAIT_BIT (49) set. It is cleared when a loaded mask has that bit clear.
- R10: busy rises the cycle after an accepted start and stays high through done. done is high for exactly one cycle. It comes on the 6th cycle after start for a restart and on the 7th cycle for the other classes.
- R11: A start that arrives while busy is high, including the done cycle, is ignored. It causes no memory request and no change of the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a swap (sampled when idle) |
| cls | input | 2 | Interrupt class |
| cur_mask | input | 64 | Live status mask |
| cur_addr | input | 64 | Live status address |
| cur_cc | input | 2 | Live condition code |
| ilen_sel | input | 3 | Instruction length or deferred-length marker |
| opc_byte | input | 8 | First opcode byte for deferred length |
| int_code | input | 16 | Supervisor-call or interruption code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write enable |
| mem_addr | output | 12 | Byte address |
| mem_wdata | output | 64 | Write data (lane order) |
| mem_rdata | input | 64 | Read data, one cycle after request |
| psw_mask | output | 64 | Current status mask |
| psw_addr | output | 64 | Current status address |
| psw_cc | output | 2 | Current condition code |
| halted | output | 1 | Core halted by the wait bit |

## Verification
The completion of one swap and the arrival of a request for the next can fall in the same cycle. The bench raises start exactly in the done cycle, and also in the middle of a sequence, with a different class and different live values. It then checks that no memory request appears afterwards and that busy falls and stays low. It also checks that the status word still shows the result of the first swap.

// File: rtl/pss_pkg.sv
package pss_pkg;
   typedef enum logic [1:0] {
      CLS_RESTART = 2'd0,
      CLS_EXT     = 2'd1,
      CLS_SVC     = 2'd2,
      CLS_PGM     = 2'd3
   } pss_cls_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_WPARM, ST_WMASK, ST_WADDR, ST_RMASK, ST_RADDR, ST_RLAST, ST_DONE
   } pss_state_e;

   localparam logic [2:0] LEN_DEFER     = 3'd1;
   localparam logic [2:0] LEN_DEFER_ADV = 3'd3;

   function automatic logic [2:0] len_of_opcode(input logic [7:0] op);
      case (op[7:6])
         2'b00:   return 3'd2;
         2'b11:   return 3'd6;
         default: return 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/pss_old_builder.sv
module pss_old_builder
   import pss_pkg::*;
#(
   parameter int W     = 64,
   parameter int CC_LO = 44
) (
   input  pss_cls_e       cls,
   input  logic [W-1:0]   mask_in,
   input  logic [W-1:0]   addr_in,
   input  logic [1:0]     cc_in,
   input  logic [2:0]     len_sel,
   input  logic [7:0]     opc,
   input  logic [15:0]    code,
   output logic [W-1:0]   old_mask,
   output logic [W-1:0]   old_addr,
   output logic [W-1:0]   parm_word
);
   localparam int PAD_W = W - 32;

   logic [2:0]  eff_len;
   logic        deferred;
   logic        bump;
   logic [15:0] len_field;

   always_comb begin
      deferred = (len_sel == LEN_DEFER) || (len_sel == LEN_DEFER_ADV);
      eff_len  = deferred ? len_of_opcode(opc) : len_sel;
      bump     = (cls == CLS_SVC) || ((cls == CLS_PGM) && (len_sel == LEN_DEFER_ADV));
      old_mask = mask_in;
      old_mask[CC_LO+1:CC_LO] = cc_in;
      old_addr = bump ? addr_in + W'(eff_len) : addr_in;
      len_field = (cls == CLS_EXT) ? 16'd0 : {13'd0, eff_len};
      parm_word = {len_field, code, {PAD_W{1'b0}}};
   end
endmodule

// File: rtl/pss_slot_map.sv
module pss_slot_map
   import pss_pkg::*;
#(
   parameter int AW          = 12,
   parameter int SAVE_BASE   = 256,
   parameter int SLOT_STRIDE = 64
) (
   input  pss_cls_e    cls,
   input  pss_state_e  state,
   output logic [AW-1:0] addr
);
   localparam int OFS_OLD_MASK = 0;
   localparam int OFS_OLD_ADDR = 8;
   localparam int OFS_NEW_MASK = 16;
   localparam int OFS_NEW_ADDR = 24;
   localparam int OFS_PARM     = 32;

   logic [AW-1:0] base;
   logic [AW-1:0] ofs;

   always_comb begin
      base = AW'(SAVE_BASE) + AW'(SLOT_STRIDE) * AW'(cls);
      case (state)
         ST_WPARM: ofs = AW'(OFS_PARM);
         ST_WMASK: ofs = AW'(OFS_OLD_MASK);
         ST_WADDR: ofs = AW'(OFS_OLD_ADDR);
         ST_RMASK: ofs = AW'(OFS_NEW_MASK);
         ST_RADDR: ofs = AW'(OFS_NEW_ADDR);
         default:  ofs = '0;
      endcase
      addr = base + ofs;
   end
endmodule

// File: rtl/pss_byte_lane.sv
module pss_byte_lane #(
   parameter int W    = 64,
   parameter bit SWAP = 1'b1
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int NB = W / 8;

   generate
      if (SWAP) begin : g_swap
         for (genvar b = 0; b < NB; b++) begin : g_byte
            assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
         end
      end else begin : g_pass
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/psw_swap_seq.sv
module psw_swap_seq
   import pss_pkg::*;
#(
   parameter int W           = 64,
   parameter int AW          = 12,
   parameter int SAVE_BASE   = 256,
   parameter int SLOT_STRIDE = 64,
   parameter int CC_LO       = 44,
   parameter int WAIT_BIT    = 49,
   parameter bit LANES_LE    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    cls,
   input  logic [63:0]   cur_mask,
   input  logic [63:0]   cur_addr,
   input  logic [1:0]    cur_cc,
   input  logic [2:0]    ilen_sel,
   input  logic [7:0]    opc_byte,
   input  logic [15:0]   int_code,
   output logic          busy,
   output logic          done,
   output logic          mem_req,
   output logic          mem_we,
   output logic [11:0]   mem_addr,
   output logic [63:0]   mem_wdata,
   input  logic [63:0]   mem_rdata,
   output logic [63:0]   psw_mask,
   output logic [63:0]   psw_addr,
   output logic [1:0]    psw_cc,
   output logic          halted
);
   localparam int SLOT_END = SAVE_BASE + 4 * SLOT_STRIDE;

   initial begin
      if (W != 64) $error("psw_swap_seq: W must be 64");
      if (AW != 12) $error("psw_swap_seq: AW must match the 12-bit port");
      if (SLOT_STRIDE < 40) $error("psw_swap_seq: slot too small");
      if (SLOT_END > (1 << AW)) $error("psw_swap_seq: save area exceeds address space");
      if (CC_LO + 1 >= W || WAIT_BIT >= W) $error("psw_swap_seq: bit position out of range");
   end

   pss_state_e    state, state_nx;
   pss_cls_e      cls_q;
   logic [W-1:0]  mask_q, addr_q, new_mask_q;
   logic [1:0]    cc_q;
   logic [2:0]    len_q;
   logic [7:0]    opc_q;
   logic [15:0]   code_q;
   logic          accept;

   logic [W-1:0]  old_mask, old_addr, parm_word;
   logic [W-1:0]  wr_word, rd_word;
   logic [AW-1:0] slot_addr;

   pss_old_builder #(.W(W), .CC_LO(CC_LO)) i_builder (
      .cls      (cls_q),
      .mask_in  (mask_q),
      .addr_in  (addr_q),
      .cc_in    (cc_q),
      .len_sel  (len_q),
      .opc      (opc_q),
      .code     (code_q),
      .old_mask (old_mask),
      .old_addr (old_addr),
      .parm_word(parm_word)
   );

   pss_slot_map #(.AW(AW), .SAVE_BASE(SAVE_BASE), .SLOT_STRIDE(SLOT_STRIDE)) i_slots (
      .cls  (cls_q),
      .state(state),
      .addr (slot_addr)
   );

   pss_byte_lane #(.W(W), .SWAP(LANES_LE)) i_wr_lane (
      .din (wr_word),
      .dout(mem_wdata)
   );

   pss_byte_lane #(.W(W), .SWAP(LANES_LE)) i_rd_lane (
      .din (mem_rdata),
      .dout(rd_word)
   );

   assign accept = (state == ST_IDLE) && start;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:  if (start) state_nx = (pss_cls_e'(cls) == CLS_RESTART) ? ST_WMASK : ST_WPARM;
         ST_WPARM: state_nx = ST_WMASK;
         ST_WMASK: state_nx = ST_WADDR;
         ST_WADDR: state_nx = ST_RMASK;
         ST_RMASK: state_nx = ST_RADDR;
         ST_RADDR: state_nx = ST_RLAST;
         ST_RLAST: state_nx = ST_DONE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_comb begin
      mem_req = (state == ST_WPARM) || (state == ST_WMASK) || (state == ST_WADDR) ||
                (state == ST_RMASK) || (state == ST_RADDR);
      mem_we  = (state == ST_WPARM) || (state == ST_WMASK) || (state == ST_WADDR);
      mem_addr = mem_req ? slot_addr : '0;
      case (state)
         ST_WPARM: wr_word = parm_word;
         ST_WMASK: wr_word = old_mask;
         ST_WADDR: wr_word = old_addr;
         default:  wr_word = '0;
      endcase
   end

   assign busy = (state != ST_IDLE);
   assign done = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cls_q  <= CLS_RESTART;
         mask_q <= '0;
         addr_q <= '0;
         cc_q   <= '0;
         len_q  <= '0;
         opc_q  <= '0;
         code_q <= '0;
      end else begin
         state <= state_nx;
         if (accept) begin
            cls_q  <= pss_cls_e'(cls);
            mask_q <= cur_mask;
            addr_q <= cur_addr;
            cc_q   <= cur_cc;
            len_q  <= ilen_sel;
            opc_q  <= opc_byte;
            code_q <= int_code;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         new_mask_q <= '0;
         psw_mask   <= '0;
         psw_addr   <= '0;
         psw_cc     <= '0;
         halted     <= 1'b0;
      end else begin
         if (state == ST_RADDR) new_mask_q <= rd_word;
         if (state == ST_RLAST) begin
            psw_mask <= new_mask_q;
            psw_addr <= rd_word;
            psw_cc   <= new_mask_q[CC_LO+1:CC_LO];
            halted   <= new_mask_q[WAIT_BIT];
         end
      end
   end
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
   parameter int CC_LO    = 44,
   parameter int WAIT_BIT = 49
) (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic        mem_req,
   input logic        mem_we,
   input logic [63:0] psw_mask,
   input logic [1:0]  psw_cc,
   input logic        halted
);
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !mem_we));
   a_r11_no_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !mem_req);
   a_r8_cc_from_mask: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (psw_cc == psw_mask[CC_LO+1:CC_LO]));
   a_r9_halt_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (halted == psw_mask[WAIT_BIT]));
   a_r8_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(psw_mask));
endmodule

bind psw_swap_seq pss_checker #(.CC_LO(CC_LO), .WAIT_BIT(WAIT_BIT)) i_pss_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .mem_req (mem_req),
   .mem_we  (mem_we),
   .psw_mask(psw_mask),
   .psw_cc  (psw_cc),
   .halted  (halted)
);

// File: tb/test_psw_swap_seq.sv
module test_psw_swap_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        start = 1'b0;
   logic [1:0]  cls = 2'd0;
   logic [63:0] cur_mask = '0, cur_addr = '0;
   logic [1:0]  cur_cc = '0;
   logic [2:0]  ilen_sel = 3'd2;
   logic [7:0]  opc_byte = '0;
   logic [15:0] int_code = '0;
   logic        busy, done, mem_req, mem_we, halted;
   logic [11:0] mem_addr;
   logic [63:0] mem_wdata, mem_rdata, psw_mask, psw_addr;
   logic [1:0]  psw_cc;

   psw_swap_seq i_psw_swap_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cls(cls), .cur_mask(cur_mask),
      .cur_addr(cur_addr), .cur_cc(cur_cc), .ilen_sel(ilen_sel), .opc_byte(opc_byte),
      .int_code(int_code), .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .psw_mask(psw_mask), .psw_addr(psw_addr), .psw_cc(psw_cc), .halted(halted)
   );

   int checks = 0, errors = 0;

   logic [63:0] mem [64];
   logic [11:0] log_a [8];
   logic [63:0] log_d [8];
   int          log_n = 0;
   int          req_n = 0;

   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         mem[mem_addr[8:3]] <= mem_wdata;
         if (log_n < 8) begin
            log_a[log_n] <= mem_addr;
            log_d[log_n] <= mem_wdata;
         end
         log_n <= log_n + 1;
      end
      if (mem_req) req_n <= req_n + 1;
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[8:3]];
   end

   function automatic logic [63:0] bswap(input logic [63:0] v);
      logic [63:0] r;
      for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
      return r;
   endfunction

   function automatic logic [2:0] op_len(input logic [7:0] op);
      if (op[7:6] == 2'b00) return 3'd2;
      if (op[7:6] == 2'b11) return 3'd6;
      return 3'd4;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [1:0]  c;
      logic [1:0]  cc;
      logic [2:0]  il;
      logic [7:0]  op;
      logic [15:0] code;
      logic [3:0]  seed;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VT [NV] = '{
      '{2'd0, 2'd1, 3'd2, 8'h00, 16'h0000, 4'd1},
      '{2'd1, 2'd2, 3'd0, 8'h00, 16'h1004, 4'd2},
      '{2'd2, 2'd3, 3'd2, 8'h0A, 16'h000A, 4'd3},
      '{2'd2, 2'd0, 3'd4, 8'h00, 16'h00FF, 4'd4},
      '{2'd3, 2'd1, 3'd6, 8'h00, 16'h0011, 4'd5},
      '{2'd3, 2'd2, 3'd1, 8'h58, 16'h0004, 4'd6},
      '{2'd3, 2'd3, 3'd3, 8'hEB, 16'h0010, 4'd7},
      '{2'd3, 2'd0, 3'd3, 8'h07, 16'h0005, 4'd0},
      '{2'd3, 2'd1, 3'd1, 8'h9A, 16'h0006, 4'd9}
   };

   function automatic logic [63:0] nmask(input logic [3:0] s);
      return 64'h0400_0000_8000_0000 | (64'(s[1:0]) << 44) | (64'(s[2]) << 49);
   endfunction

   // issue one swap and wait for done; returns cycles from start to done
   task automatic run(input vec_t v, output int cyc);
      @(negedge clk);
      cls = v.c; cur_cc = v.cc; ilen_sel = v.il; opc_byte = v.op; int_code = v.code;
      cur_mask = 64'h0730_0000_0000_0000 ^ (64'(v.seed) << 40);
      cur_addr = 64'h0010_0000 + 64'(v.seed) * 64'h100;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin
      int cyc;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      mem_rdata = '0;
      #20;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 done", 64'(done), 64'd0);
      chk("R1 mem_req", 64'({mem_req, mem_we}), 64'd0);
      chk("R1 halted", 64'(halted), 64'd0);
      chk("R1 status", psw_mask | psw_addr | 64'(psw_cc), 64'd0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         vec_t v = VT[k];
         logic [11:0] base = 12'h100 + 12'd64 * 12'(v.c);
         logic [63:0] om, oa, pw, nm, na;
         logic [2:0]  ln;
         int          p;
         nm = nmask(v.seed);
         na = 64'h2000 + 64'(v.seed) * 64'h10;
         mem[(base + 12'd16) >> 3] = bswap(nm);
         mem[(base + 12'd24) >> 3] = bswap(na);
         ln = (v.il == 3'd1 || v.il == 3'd3) ? op_len(v.op) : v.il;
         om = (64'h0730_0000_0000_0000 ^ (64'(v.seed) << 40)) & ~(64'h3 << 44);
         om = om | (64'(v.cc) << 44);
         oa = 64'h0010_0000 + 64'(v.seed) * 64'h100;
         if (v.c == 2'd2 || (v.c == 2'd3 && v.il == 3'd3)) oa = oa + 64'(ln);
         pw = {(v.c == 2'd1) ? 16'd0 : 16'(ln), v.code, 32'd0};
         @(negedge clk);
         log_n = 0;
         run(v, cyc);
         // R10 latency and pulse
         chk("R10 done latency", 64'(cyc), (v.c == 2'd0) ? 64'd6 : 64'd7);
         chk("R2 write count", 64'(log_n), (v.c == 2'd0) ? 64'd2 : 64'd3);
         p = 0;
         if (v.c != 2'd0) begin
            chk("R2 parm addr", 64'(log_a[0]), 64'(base + 12'd32));
            if (v.c == 2'd1) chk("R7 ext parm", log_d[0], bswap(pw));
            else if (v.c == 2'd2) chk("R5 svc parm", log_d[0], bswap(pw));
            else chk("R6 pgm parm", log_d[0], bswap(pw));
            p = 1;
         end
         chk("R2 mask addr", 64'(log_a[p]), 64'(base));
         chk("R3 R4 old mask", log_d[p], bswap(om));
         chk("R2 addr addr", 64'(log_a[p+1]), 64'(base + 12'd8));
         if (v.c == 2'd2) chk("R5 svc old addr", log_d[p+1], bswap(oa));
         else chk("R6 old addr", log_d[p+1], bswap(oa));
         chk("R8 new mask", psw_mask, nm);
         chk("R8 new addr", psw_addr, na);
         chk("R8 cc", 64'(psw_cc), 64'(v.seed[1:0]));
         chk("R9 halted", 64'(halted), 64'(v.seed[2]));
         @(negedge clk);
         chk("R10 busy low after done", 64'(busy), 64'd0);
      end

      // R11: start in mid-sequence and on the done cycle
      begin
         vec_t a = VT[2];
         vec_t b = VT[7];
         logic [63:0] pm;
         int r0;
         @(negedge clk);
         r0 = req_n;
         @(negedge clk);
         cls = a.c; cur_cc = a.cc; ilen_sel = a.il; opc_byte = a.op; int_code = a.code;
         cur_mask = 64'h1; cur_addr = 64'h40; start = 1'b1;
         @(negedge clk);
         cls = b.c; ilen_sel = b.il; opc_byte = b.op; cur_addr = 64'h999;
         @(negedge clk);
         @(negedge clk);
         start = 1'b0;
         while (!done) @(negedge clk);
         pm = psw_mask;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk("R11 busy ignores start at done", 64'(busy), 64'd0);
         @(negedge clk);
         @(negedge clk);
         chk("R11 no extra requests", 64'(req_n - r0), 64'd5);
         chk("R11 status kept", psw_mask, pm);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule